// File: doc/BRIEF.md
# Programmable raster timing generator

This block produces the horizontal and vertical timing of a display raster from programmed values. A pixel counter runs from zero to the programmed horizontal total. Each time it wraps, a line counter advances, and the line counter runs from zero to the programmed vertical total. Comparators on the two counts produce the active-video, blanking and sync outputs. The current pixel and line coordinates are also brought out for downstream logic.

Every position is programmed as a zero-based count, which is the count minus one. Horizontal sync may start on any pixel. Settings that break the sync rules raise an error flag and silence both syncs. An interlace mode alternates a field bit and moves the odd field's vertical sync by half a line. A centering mode shifts the vertical blank and sync positions up when the displayed height is smaller than the panel height.

Values are written through a simple write port into shadow registers. They move into the working set only when the frame wraps, so no frame ever runs with a mix of old and new settings.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel count `pixX` counts 0,1,…,hTotal and then returns to 0. The line count `lineY` holds its value except when `pixX` equals hTotal: it then advances by one, or returns to 0 when it equals vTotal.
- R2: `activeVideo` is 1 exactly when pixX ≤ hActive and lineY ≤ vActive.
- R3: `blank` is 1 exactly when pixX lies within [hBlankStart, hBlankEnd] or lineY lies within the effective [vBlankStart, vBlankEnd]. Both ranges are inclusive.
- R4: When there is no error, `hSync` is 1 exactly for pixX within [hSyncStart, hSyncEnd], and hSyncStart may be any pixel. In the even field, or without interlace, `vSync` is 1 exactly for lineY within the effective [vSyncStart, vSyncEnd].
- R5: `syncErr` is 1 when hSyncEnd − hSyncStart < 7, meaning a sync narrower than 8 pixels. It is also 1 when hSyncStart < hBlankStart + 8. While `syncErr` is 1, `hSync` and `vSync` are 0.
- R6: `syncErr` is also 1 when vTotal ≤ vActive. With interlace enabled it is also 1 when vTotal is odd or vActive is even.
- R7: Writes land in shadow registers. The whole shadow set is copied into the working set only on the clock edge where pixX = hTotal and lineY = vTotal.
- R8: When centering is enabled and vPanel > vActive, the copy subtracts adj = (vPanel − vActive) / 2, rounded down, from vBlankStart, vBlankEnd, vSyncStart and vSyncEnd. Each result saturates at 0. Otherwise these four values are copied unchanged.
- R9: At each copy, `field` toggles if the incoming set has interlace enabled, and is cleared to 0 otherwise.
- R10: When `field` is 1, `vSync` is 1 from pixel half = (hTotal+1)/2 (rounded down) of line vSyncStart up to pixel half−1 of line vSyncEnd+1. This keeps the even-field pulse length but delays it by half a line.
- R11: The register map, with lo = bits [11:0] or [10:0] and hi = bits [27:16] or [26:16], is:
  - address 0: hTotal (lo), hActive (hi)
  - address 1: hBlankStart (lo), hBlankEnd (hi)
  - address 2: hSyncStart (lo), hSyncEnd (hi)
  - address 3: vTotal (lo), vActive (hi)
  - address 4: vBlankStart (lo), vBlankEnd (hi)
  - address 5: vSyncStart (lo), vSyncEnd (hi)
  - address 6: vPanel in bits [10:0], interlace in bit 16, centering in bit 17

  All other bits, and address 7, are ignored.
- R12: After reset, both counts are 0 and all shadow and working values are 0. The outputs are therefore `syncErr`=1, `hSync`=`vSync`=0, `field`=0, `activeVideo`=1 and `blank`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| pixX | output | HW (12) | Current pixel count |
| lineY | output | VW (11) | Current line count |
| activeVideo | output | 1 | Inside the displayed area |
| blank | output | 1 | Horizontal or vertical blanking |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| field | output | 1 | Interlace field, 1 = odd |
| syncErr | output | 1 | Illegal working timing; syncs silenced |

## Verification
The bench builds the block with its default widths, HW=12 and VW=11, so the full register field widths and the reserved-bit masking are exercised. It then programs a tiny raster of 32 pixels by roughly 10 lines, which brings every pixel of every line within reach of a few thousand cycles. An arithmetic model of the counters, commit rule, centering shift, field toggle and half-line delay is compared against every output on every cycle. This covers a sweep of horizontal sync starts, the centered, interlaced and error-raising settings, and a write made in the middle of a frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Bit position of the upper field in a packed register word
  localparam int FIELD_HI_LSB = 16;
  // Minimum horizontal sync width and minimum gap after blank start, in pixels
  localparam int MIN_SYNC_PIX = 8;

  typedef enum logic [2:0] {
    ADDR_H_SPAN  = 3'd0,
    ADDR_H_BLANK = 3'd1,
    ADDR_H_SYNC  = 3'd2,
    ADDR_V_SPAN  = 3'd3,
    ADDR_V_BLANK = 3'd4,
    ADDR_V_SYNC  = 3'd5,
    ADDR_PANEL   = 3'd6
  } regAddr_e;

  // Datapath to control: counter end markers
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
  } rasterStatus_t;

  // Control to datapath: strobes
  typedef struct packed {
    logic syncKill;
    logic oddField;
  } ctrlStrobe_t;

endpackage

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [31:0]   wrData,
  input  rasterStatus_t status,
  output logic [HW-1:0] hTotal,
  output logic [HW-1:0] hActive,
  output logic [HW-1:0] hBlankS,
  output logic [HW-1:0] hBlankE,
  output logic [HW-1:0] hSyncS,
  output logic [HW-1:0] hSyncE,
  output logic [VW-1:0] vTotal,
  output logic [VW-1:0] vActive,
  output logic [VW-1:0] vBlankS,
  output logic [VW-1:0] vBlankE,
  output logic [VW-1:0] vSyncS,
  output logic [VW-1:0] vSyncE,
  output ctrlStrobe_t   strobe,
  output logic          field,
  output logic          syncErr
);

  localparam int HI = FIELD_HI_LSB;

  typedef struct packed {
    logic [HW-1:0] hTotal;
    logic [HW-1:0] hActive;
    logic [HW-1:0] hBlankS;
    logic [HW-1:0] hBlankE;
    logic [HW-1:0] hSyncS;
    logic [HW-1:0] hSyncE;
    logic [VW-1:0] vTotal;
    logic [VW-1:0] vActive;
    logic [VW-1:0] vBlankS;
    logic [VW-1:0] vBlankE;
    logic [VW-1:0] vSyncS;
    logic [VW-1:0] vSyncE;
    logic          interlace;
  } timingSet_t;

  timingSet_t    shadowSet;
  timingSet_t    nextSet;
  timingSet_t    workSet;
  logic [VW-1:0] shPanel;
  logic          shCenter;
  logic [VW-1:0] adjAmt;
  logic          commit;

  // Shadow register writes; reserved bits are never stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowSet <= '0;
      shPanel   <= '0;
      shCenter  <= 1'b0;
    end else if (wrEn) begin
      case (regAddr_e'(wrAddr))
        ADDR_H_SPAN: begin
          shadowSet.hTotal  <= wrData[HW-1:0];
          shadowSet.hActive <= wrData[HI +: HW];
        end
        ADDR_H_BLANK: begin
          shadowSet.hBlankS <= wrData[HW-1:0];
          shadowSet.hBlankE <= wrData[HI +: HW];
        end
        ADDR_H_SYNC: begin
          shadowSet.hSyncS <= wrData[HW-1:0];
          shadowSet.hSyncE <= wrData[HI +: HW];
        end
        ADDR_V_SPAN: begin
          shadowSet.vTotal  <= wrData[VW-1:0];
          shadowSet.vActive <= wrData[HI +: VW];
        end
        ADDR_V_BLANK: begin
          shadowSet.vBlankS <= wrData[VW-1:0];
          shadowSet.vBlankE <= wrData[HI +: VW];
        end
        ADDR_V_SYNC: begin
          shadowSet.vSyncS <= wrData[VW-1:0];
          shadowSet.vSyncE <= wrData[HI +: VW];
        end
        ADDR_PANEL: begin
          shPanel             <= wrData[VW-1:0];
          shadowSet.interlace <= wrData[HI];
          shCenter            <= wrData[HI+1];
        end
        default: ;
      endcase
    end
  end

  function automatic logic [VW-1:0] satSub(input logic [VW-1:0] a, input logic [VW-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  // Centering shift for the vertical blank and sync positions
  always_comb begin
    adjAmt = '0;
    if (shCenter && (shPanel > shadowSet.vActive))
      adjAmt = (shPanel - shadowSet.vActive) >> 1;
  end

  always_comb begin
    nextSet         = shadowSet;
    nextSet.vBlankS = satSub(shadowSet.vBlankS, adjAmt);
    nextSet.vBlankE = satSub(shadowSet.vBlankE, adjAmt);
    nextSet.vSyncS  = satSub(shadowSet.vSyncS, adjAmt);
    nextSet.vSyncE  = satSub(shadowSet.vSyncE, adjAmt);
  end

  assign commit = status.lineEnd && status.frameEnd;

  // Working set and field bit change only at frame wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workSet <= '0;
      field   <= 1'b0;
    end else if (commit) begin
      workSet <= nextSet;
      field   <= nextSet.interlace ? ~field : 1'b0;
    end
  end

  // Legality checks on the working set
  logic hWidthBad;
  logic hGapBad;
  logic vOrderBad;
  logic ilaceBad;

  always_comb begin
    hWidthBad = (workSet.hSyncE < workSet.hSyncS) ||
                ((workSet.hSyncE - workSet.hSyncS) < HW'(MIN_SYNC_PIX - 1));
    hGapBad   = ({1'b0, workSet.hSyncS} < ({1'b0, workSet.hBlankS} + (HW+1)'(MIN_SYNC_PIX)));
    vOrderBad = (workSet.vTotal <= workSet.vActive);
    ilaceBad  = workSet.interlace && (workSet.vTotal[0] || !workSet.vActive[0]);
    syncErr   = hWidthBad || hGapBad || vOrderBad || ilaceBad;
  end

  assign strobe.syncKill = syncErr;
  assign strobe.oddField = field;

  assign hTotal  = workSet.hTotal;
  assign hActive = workSet.hActive;
  assign hBlankS = workSet.hBlankS;
  assign hBlankE = workSet.hBlankE;
  assign hSyncS  = workSet.hSyncS;
  assign hSyncE  = workSet.hSyncE;
  assign vTotal  = workSet.vTotal;
  assign vActive = workSet.vActive;
  assign vBlankS = workSet.vBlankS;
  assign vBlankE = workSet.vBlankE;
  assign vSyncS  = workSet.vSyncS;
  assign vSyncE  = workSet.vSyncE;

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(workSet)); // R7

  AST_FIELD_PROGRESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !workSet.interlace |-> !field); // R9

  AST_SHADOW_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || (wrAddr == 3'd7)) |=> $stable(shadowSet)); // R11

endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [HW-1:0] hTotal,
  input  logic [HW-1:0] hActive,
  input  logic [HW-1:0] hBlankS,
  input  logic [HW-1:0] hBlankE,
  input  logic [HW-1:0] hSyncS,
  input  logic [HW-1:0] hSyncE,
  input  logic [VW-1:0] vTotal,
  input  logic [VW-1:0] vActive,
  input  logic [VW-1:0] vBlankS,
  input  logic [VW-1:0] vBlankE,
  input  logic [VW-1:0] vSyncS,
  input  logic [VW-1:0] vSyncE,
  input  ctrlStrobe_t   strobe,
  output rasterStatus_t status,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          activeVideo,
  output logic          blank,
  output logic          hSyncOut,
  output logic          vSyncOut
);

  assign status.lineEnd  = (hCount == hTotal);
  assign status.frameEnd = (vCount == vTotal);

  // Pixel and line counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else if (status.lineEnd) begin
      hCount <= '0;
      vCount <= status.frameEnd ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  logic [HW:0]   hSpan;
  logic [HW-1:0] halfPix;
  logic [VW:0]   vSyncEndNext;
  logic          hBlankIn;
  logic          vBlankIn;
  logic          hSyncIn;
  logic          vSyncEven;
  logic          vSyncOdd;

  always_comb begin
    hSpan        = {1'b0, hTotal} + 1'b1;
    halfPix      = hSpan[HW:1];
    vSyncEndNext = {1'b0, vSyncE} + 1'b1;

    activeVideo  = (hCount <= hActive) && (vCount <= vActive);
    hBlankIn     = (hCount >= hBlankS) && (hCount <= hBlankE);
    vBlankIn     = (vCount >= vBlankS) && (vCount <= vBlankE);
    blank        = hBlankIn || vBlankIn;

    hSyncIn      = (hCount >= hSyncS) && (hCount <= hSyncE);
    vSyncEven    = (vCount >= vSyncS) && (vCount <= vSyncE);
    vSyncOdd     = ((vCount == vSyncS) && (hCount >= halfPix)) ||
                   ((vCount > vSyncS) && (vCount <= vSyncE)) ||
                   (({1'b0, vCount} == vSyncEndNext) && (hCount < halfPix));

    hSyncOut     = !strobe.syncKill && hSyncIn;
    vSyncOut     = !strobe.syncKill && (strobe.oddField ? vSyncOdd : vSyncEven);
  end

  AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    status.lineEnd |=> (hCount == '0)); // R1

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !status.lineEnd |=> (hCount == $past(hCount) + 1'b1)); // R1

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !status.lineEnd |=> $stable(vCount)); // R1

  AST_ERR_SILENCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.syncKill |-> (!hSyncOut && !vSyncOut)); // R5

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [31:0]   wrData,
  output logic [HW-1:0] pixX,
  output logic [VW-1:0] lineY,
  output logic          activeVideo,
  output logic          blank,
  output logic          hSync,
  output logic          vSync,
  output logic          field,
  output logic          syncErr
);

  rasterStatus_t status;
  ctrlStrobe_t   strobe;
  logic [HW-1:0] hTotal, hActive, hBlankS, hBlankE, hSyncS, hSyncE;
  logic [VW-1:0] vTotal, vActive, vBlankS, vBlankE, vSyncS, vSyncE;

  rtg_ctrl #(.HW(HW), .VW(VW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .status(status),
    .hTotal(hTotal), .hActive(hActive), .hBlankS(hBlankS), .hBlankE(hBlankE),
    .hSyncS(hSyncS), .hSyncE(hSyncE),
    .vTotal(vTotal), .vActive(vActive), .vBlankS(vBlankS), .vBlankE(vBlankE),
    .vSyncS(vSyncS), .vSyncE(vSyncE),
    .strobe(strobe), .field(field), .syncErr(syncErr)
  );

  rtg_datapath #(.HW(HW), .VW(VW)) u_datapath (
    .clk(clk), .rstN(rstN),
    .hTotal(hTotal), .hActive(hActive), .hBlankS(hBlankS), .hBlankE(hBlankE),
    .hSyncS(hSyncS), .hSyncE(hSyncE),
    .vTotal(vTotal), .vActive(vActive), .vBlankS(vBlankS), .vBlankE(vBlankE),
    .vSyncS(vSyncS), .vSyncE(vSyncE),
    .strobe(strobe), .status(status),
    .hCount(pixX), .vCount(lineY),
    .activeVideo(activeVideo), .blank(blank),
    .hSyncOut(hSync), .vSyncOut(vSync)
  );

endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [11:0] pixX;
  logic [10:0] lineY;
  logic        activeVideo, blank, hSync, vSync, field, syncErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phase = "R11";

  // Model state: shadow, working, counters
  int sHT, sHA, sHBS, sHBE, sHSS, sHSE, sVT, sVA, sVBS, sVBE, sVSS, sVSE, sVP, sIl, sCe;
  int wHT, wHA, wHBS, wHBE, wHSS, wHSE, wVT, wVA, wVBS, wVBE, wVSS, wVSE, wIl;
  int mH, mV, mField;

  always #10 clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixX(pixX), .lineY(lineY), .activeVideo(activeVideo), .blank(blank),
    .hSync(hSync), .vSync(vSync), .field(field), .syncErr(syncErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [phase %s] at pix=%0d line=%0d: actual=%0d expected=%0d",
               tag, phase, mH, mV, act, exp);
    end
  endtask

  function automatic int pk(input int lo, input int hi);
    return (hi << 16) | lo;
  endfunction

  function automatic int satSub(input int a, input int b);
    return (a > b) ? a - b : 0;
  endfunction

  task automatic modelReset();
    {sHT, sHA, sHBS, sHBE, sHSS, sHSE, sVT, sVA, sVBS, sVBE, sVSS, sVSE, sVP, sIl, sCe} = '0;
    {wHT, wHA, wHBS, wHBE, wHSS, wHSE, wVT, wVA, wVBS, wVBE, wVSS, wVSE, wIl} = '0;
    mH = 0; mV = 0; mField = 0;
  endtask

  function automatic bit expErr();
    return (wHSE < wHSS) || (wHSE - wHSS < 7) || (wHSS < wHBS + 8) ||
           (wVT <= wVA) || (wIl != 0 && ((wVT % 2) == 1 || (wVA % 2) == 0));
  endfunction

  // Compare every output with the arithmetic model (R1..R6, R8, R9, R10)
  task automatic compareAll();
    bit e;
    int half;
    bit vs;
    e = expErr();
    half = (wHT + 1) / 2;
    if (mField != 0)
      vs = (mV == wVSS && mH >= half) || (mV > wVSS && mV <= wVSE) ||
           (mV == wVSE + 1 && mH < half);
    else
      vs = (mV >= wVSS && mV <= wVSE);
    chk("R1", int'(pixX), mH);
    chk("R1", int'(lineY), mV);
    chk("R2", int'(activeVideo), int'(mH <= wHA && mV <= wVA));
    chk(sCe != 0 ? "R8" : "R3", int'(blank),
        int'((mH >= wHBS && mH <= wHBE) || (mV >= wVBS && mV <= wVBE)));
    chk(e ? "R5" : "R4", int'(hSync), int'(!e && mH >= wHSS && mH <= wHSE));
    chk(mField != 0 ? "R10" : "R4", int'(vSync), int'(!e && vs));
    chk("R9", int'(field), mField);
    chk((wVT <= wVA || wIl != 0) ? "R6" : "R5", int'(syncErr), int'(e));
  endtask

  task automatic modelAdvance(input bit we, input int a, input int d);
    bit hEnd, vEnd;
    int adj;
    hEnd = (mH == wHT);
    vEnd = (mV == wVT);
    if (hEnd) begin
      mH = 0;
      mV = vEnd ? 0 : mV + 1;
    end else mH = mH + 1;
    if (hEnd && vEnd) begin
      adj = (sCe != 0 && sVP > sVA) ? (sVP - sVA) / 2 : 0;
      wHT = sHT; wHA = sHA; wHBS = sHBS; wHBE = sHBE; wHSS = sHSS; wHSE = sHSE;
      wVT = sVT; wVA = sVA; wIl = sIl;
      wVBS = satSub(sVBS, adj); wVBE = satSub(sVBE, adj);
      wVSS = satSub(sVSS, adj); wVSE = satSub(sVSE, adj);
      mField = (sIl != 0) ? (mField == 0 ? 1 : 0) : 0;
    end
    if (we) begin
      case (a)
        0: begin sHT = d & 'hFFF; sHA = (d >> 16) & 'hFFF; end
        1: begin sHBS = d & 'hFFF; sHBE = (d >> 16) & 'hFFF; end
        2: begin sHSS = d & 'hFFF; sHSE = (d >> 16) & 'hFFF; end
        3: begin sVT = d & 'h7FF; sVA = (d >> 16) & 'h7FF; end
        4: begin sVBS = d & 'h7FF; sVBE = (d >> 16) & 'h7FF; end
        5: begin sVSS = d & 'h7FF; sVSE = (d >> 16) & 'h7FF; end
        6: begin sVP = d & 'h7FF; sIl = (d >> 16) & 1; sCe = (d >> 17) & 1; end
        default: ;
      endcase
    end
  endtask

  task automatic tick(input bit we, input int a, input int d);
    @(negedge clk);
    compareAll();
    wrEn = we; wrAddr = a[2:0]; wrData = d;
    @(posedge clk);
    #1;
    modelAdvance(we, a, d);
    wrEn = 1'b0;
  endtask

  task automatic writeReg(input int a, input int d);
    tick(1'b1, a, d);
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R12: reset state with an all-zero configuration
    phase = "R12";
    chk("R12", int'(pixX), 0);
    chk("R12", int'(lineY), 0);
    chk("R12", int'(hSync), 0);
    chk("R12", int'(vSync), 0);
    chk("R12", int'(field), 0);
    chk("R12", int'(syncErr), 1);
    chk("R12", int'(activeVideo), 1);
    chk("R12", int'(blank), 1);

    // R11: base raster with reserved bits set, plus a write to the unused address
    phase = "R11";
    writeReg(0, pk(31, 7) | 32'hF000F000);
    writeReg(1, pk(8, 31) | 32'hF000F000);
    writeReg(2, pk(16, 23) | 32'hF000F000);
    writeReg(3, pk(9, 5) | 32'hF800F800);
    writeReg(4, pk(6, 9));
    writeReg(5, pk(7, 8));
    writeReg(6, pk(5, 0) | 32'hF000F800);
    writeReg(7, 32'hFFFFFFFF);
    runCycles(700);
    chk("R11", int'(syncErr), 0);

    // R7: write in mid-frame, old horizontal sync still used until frame wrap
    phase = "R7";
    while (mV != 2) tick(1'b0, 0, 0);
    writeReg(2, pk(20, 27));
    while (mH != 16) tick(1'b0, 0, 0);
    chk("R7", int'(hSync), 1);
    runCycles(700);

    // R8: centering shift of vertical blank and sync
    phase = "R8";
    writeReg(3, pk(11, 3));
    writeReg(6, pk(7, 0) | (1 << 17));
    while (!(wVBS == 4 && mV == 4 && mH == 0)) tick(1'b0, 0, 0);
    chk("R8", int'(blank), 1);
    runCycles(800);

    // R9, R10: interlace with legal parity
    phase = "R10";
    writeReg(3, pk(10, 5));
    writeReg(4, pk(6, 10));
    writeReg(5, pk(7, 8));
    writeReg(6, 1 << 16);
    while (!(mField == 1 && mV == 7 && mH == 15)) tick(1'b0, 0, 0);
    chk("R10", int'(vSync), 0);
    tick(1'b0, 0, 0);
    chk("R10", int'(vSync), 1);
    runCycles(1100);

    // R6: interlace with wrong parity, then total not above active
    phase = "R6";
    writeReg(3, pk(9, 5));
    runCycles(700);
    chk("R6", int'(syncErr), 1);
    writeReg(6, 0);
    writeReg(3, pk(5, 5));
    runCycles(700);
    chk("R6", int'(syncErr), 1);
    writeReg(3, pk(9, 5));
    writeReg(4, pk(6, 9));
    runCycles(700);

    // R5: sync 7 pixels wide, then sync starting 7 pixels after blank start
    phase = "R5";
    writeReg(2, pk(16, 22));
    runCycles(700);
    chk("R5", int'(syncErr), 1);
    writeReg(2, pk(15, 22));
    runCycles(700);
    chk("R5", int'(syncErr), 1);

    // R4: sweep of horizontal sync start over single pixel steps
    phase = "R4";
    for (int s = 16; s <= 24; s++) begin
      writeReg(2, pk(s, s + 7));
      runCycles(650);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule